// File: doc/BRIEF.md
# Read-Modify-Write Group Checker

This block watches the request stream of one memory port and polices groups of atomic read-modify-write operations. Every issued RMW-read opens or widens a group, every RMW-write retires one member of it, and when writes have caught up with reads the group is closed and both tallies fall back to zero. Several RMW-reads may therefore be followed by the same number of RMW-writes. A plain access (load, store, instruction fetch) that arrives while a group holds only reads means the group was abandoned: the block then pulses a reset of all atomic line flags and forgets the group. A plain access that finds a group half written, or any RMW operation out of order, is a protocol violation and raises a sticky error.

On the completion side the block turns finished RMW-reads into a "set atomic flag" command for the completed line and finished RMW-writes into a "clear atomic flag" command. It also classifies every issued request for the downstream queue: whether it travels as an atomic-class access and whether it is tracked as a write-class pending request. All outputs are registered and appear one clock after the strobe that caused them.

Top module: `rmw_seq_chk`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is 0.
- R2: An issued RMW-read (kind code 3) with write tally zero and read tally below MAX_GROUP adds one to the read tally and raises no error.
- R3: An issued RMW-write (kind code 4) with a nonzero read tally and write tally below it adds one to the write tally; when the tallies become equal both return to zero, so a later plain access causes neither reset-all nor error.
- R4: A plain access (kind codes 0 load, 1 store, 2 fetch) issued while the read tally is nonzero and the write tally zero pulses `atom_reset_all` for one cycle in the next cycle and clears both tallies.
- R5: A violation raises `proto_err` in the next cycle: an RMW-read while the write tally is nonzero, an RMW-write with read tally zero or write tally already equal to it, or a plain access while the write tally is nonzero; tallies are left unchanged by a violation.
- R6: `proto_err` stays high until reset once set.
- R7: An RMW-read arriving with the read tally already at MAX_GROUP is a violation (overflow) and raises `proto_err`; exactly MAX_GROUP reads followed by MAX_GROUP writes is legal.
- R8: A completion with kind 3 pulses `flag_set`, with kind 4 pulses `flag_clr`, one cycle later, with `flag_line` equal to the completion line; completions of other kinds pulse neither.
- R9: For an issued request, `iss_atomic` is high one cycle later for kinds 3, 4, 5 (locked read) and 6 (locked write); `iss_wr_class` is high for kinds 1, 3, 4, 5, 6; kind 7 and idle cycles give neither. Kinds 5, 6 and 7 leave the tallies untouched.
- R10: Issue handling and completion handling are independent: both act in the same cycle when both strobes are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A request is issued this cycle |
| iss_kind | input | 3 | Kind code of the issued request |
| cmp_valid | input | 1 | A request completes this cycle |
| cmp_kind | input | 3 | Kind code of the completed request |
| cmp_line | input | LINE_W | Line address of the completed request |
| flag_set | output | 1 | Set the atomic flag of `flag_line` |
| flag_clr | output | 1 | Clear the atomic flag of `flag_line` |
| flag_line | output | LINE_W | Line for the flag command |
| atom_reset_all | output | 1 | Clear every atomic flag |
| proto_err | output | 1 | Sticky protocol violation |
| iss_atomic | output | 1 | Last issued request is atomic-class |
| iss_wr_class | output | 1 | Last issued request is write-class pending |

## Verification
The two functions that can coincide are the abandon detection on the issue side and the flag command on the completion side: a plain load issued to an open read-only group in the very cycle an RMW-read completes must yield both `atom_reset_all` and `flag_set` together in the next cycle. The bench provokes this, and also a completion of an RMW-write alongside an RMW-write issue that closes its group, and judges every output in every cycle against a behavioural model that keeps the two tallies as plain integers.

// File: rtl/rmwc_pkg.sv
package rmwc_pkg;
  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_STORE   = 3'd1,
    K_IFETCH  = 3'd2,
    K_RMW_RD  = 3'd3,
    K_RMW_WR  = 3'd4,
    K_LOCK_RD = 3'd5,
    K_LOCK_WR = 3'd6,
    K_NONE    = 3'd7
  } kind_e;
endpackage

// File: rtl/rmwc_group.sv
module rmwc_group
  import rmwc_pkg::*;
#(
  parameter int MAX_GROUP = 4,
  localparam int CNT_W = $clog2(MAX_GROUP + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       iss_valid,
  input  logic [2:0] iss_kind,
  output logic       reset_all_q,
  output logic       err_q
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(MAX_GROUP);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] rd_q, wr_q, rd_d, wr_d;
  logic             viol, abandon;
  kind_e            k;

  assign k = kind_e'(iss_kind);

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    viol    = 1'b0;
    abandon = 1'b0;
    if (iss_valid) begin
      case (k)
        K_RMW_RD: begin
          if (wr_q != ZERO || rd_q == TOP) viol = 1'b1;
          else rd_d = rd_q + ONE;
        end
        K_RMW_WR: begin
          if (rd_q == ZERO || wr_q >= rd_q) viol = 1'b1;
          else if (wr_q + ONE == rd_q) begin
            rd_d = ZERO;
            wr_d = ZERO;
          end else wr_d = wr_q + ONE;
        end
        K_LOAD, K_STORE, K_IFETCH: begin
          if (rd_q != ZERO && wr_q == ZERO) begin
            abandon = 1'b1;
            rd_d    = ZERO;
            wr_d    = ZERO;
          end else if (wr_q != ZERO) viol = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= ZERO;
      wr_q        <= ZERO;
      reset_all_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rd_q        <= rd_d;
      wr_q        <= wr_d;
      reset_all_q <= abandon;
      err_q       <= err_q | viol;
    end
  end
endmodule

// File: rtl/rmwc_flag.sv
module rmwc_flag
  import rmwc_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  output logic              set_q,
  output logic              clr_q,
  output logic [LINE_W-1:0] line_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      line_q <= '0;
    end else begin
      set_q <= cmp_valid && (kind_e'(cmp_kind) == K_RMW_RD);
      clr_q <= cmp_valid && (kind_e'(cmp_kind) == K_RMW_WR);
      if (cmp_valid) line_q <= cmp_line;
    end
  end
endmodule

// File: rtl/rmwc_class.sv
module rmwc_class
  import rmwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       iss_valid,
  input  logic [2:0] iss_kind,
  output logic       atomic_q,
  output logic       wrcls_q
);
  logic atomic_d, wrcls_d;

  always_comb begin
    atomic_d = 1'b0;
    wrcls_d  = 1'b0;
    if (iss_valid) begin
      case (kind_e'(iss_kind))
        K_RMW_RD, K_RMW_WR, K_LOCK_RD, K_LOCK_WR: begin
          atomic_d = 1'b1;
          wrcls_d  = 1'b1;
        end
        K_STORE: wrcls_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      atomic_q <= 1'b0;
      wrcls_q  <= 1'b0;
    end else begin
      atomic_q <= atomic_d;
      wrcls_q  <= wrcls_d;
    end
  end
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int MAX_GROUP = 4,
  parameter int LINE_W    = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [2:0]        iss_kind,
  input  logic              cmp_valid,
  input  logic [2:0]        cmp_kind,
  input  logic [LINE_W-1:0] cmp_line,
  output logic              flag_set,
  output logic              flag_clr,
  output logic [LINE_W-1:0] flag_line,
  output logic              atom_reset_all,
  output logic              proto_err,
  output logic              iss_atomic,
  output logic              iss_wr_class
);
  rmwc_group #(.MAX_GROUP(MAX_GROUP)) u_group (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .reset_all_q(atom_reset_all), .err_q(proto_err)
  );

  rmwc_flag #(.LINE_W(LINE_W)) u_flag (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
    .cmp_line(cmp_line), .set_q(flag_set), .clr_q(flag_clr), .line_q(flag_line)
  );

  rmwc_class u_class (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .atomic_q(iss_atomic), .wrcls_q(iss_wr_class)
  );
endmodule

// File: rtl/rmw_seq_chk_sva.sv
module rmw_seq_chk_sva #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic [2:0]        iss_kind,
  input logic              cmp_valid,
  input logic [2:0]        cmp_kind,
  input logic [LINE_W-1:0] cmp_line,
  input logic              flag_set,
  input logic              flag_clr,
  input logic [LINE_W-1:0] flag_line,
  input logic              atom_reset_all,
  input logic              proto_err,
  input logic              iss_atomic,
  input logic              iss_wr_class
);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $past(iss_valid));

  // R4
  reset_all_cause_chk: assert property (@(posedge clk) disable iff (rst)
    atom_reset_all |-> $past(iss_valid && iss_kind <= 3'd2));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_kind == 3'd3) |=> (flag_set && !flag_clr && flag_line == $past(cmp_line)));

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_kind == 3'd4) |=> (flag_clr && !flag_set && flag_line == $past(cmp_line)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> (!iss_atomic && !iss_wr_class && !atom_reset_all));

  // R9
  rmw_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_kind == 3'd3 || iss_kind == 3'd4)) |=> (iss_atomic && iss_wr_class));
endmodule

bind rmw_seq_chk rmw_seq_chk_sva #(.LINE_W(LINE_W)) u_sva (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
  .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line),
  .flag_set(flag_set), .flag_clr(flag_clr), .flag_line(flag_line),
  .atom_reset_all(atom_reset_all), .proto_err(proto_err),
  .iss_atomic(iss_atomic), .iss_wr_class(iss_wr_class)
);

// File: tb/rmw_seq_chk_test.sv
module rmw_seq_chk_test;
  localparam int CLK_P = 10;
  localparam int MAXG  = 4;
  localparam int LW    = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic [2:0]    iss_kind = 3'd0;
  logic          cmp_valid = 1'b0;
  logic [2:0]    cmp_kind = 3'd0;
  logic [LW-1:0] cmp_line = '0;
  logic          flag_set, flag_clr, atom_reset_all, proto_err, iss_atomic, iss_wr_class;
  logic [LW-1:0] flag_line;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // behavioural model state
  int m_rd = 0;
  int m_wr = 0;
  bit m_err = 0;

  rmw_seq_chk #(.MAX_GROUP(MAXG), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line),
    .flag_set(flag_set), .flag_clr(flag_clr), .flag_line(flag_line),
    .atom_reset_all(atom_reset_all), .proto_err(proto_err),
    .iss_atomic(iss_atomic), .iss_wr_class(iss_wr_class)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, act, exp);
    end
  endtask

  // R1
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iss_valid = 1'b0; cmp_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1", "err in reset", proto_err, 0);
    chk("R1", "reset_all in reset", atom_reset_all, 0);
    chk("R1", "flags in reset", {flag_set, flag_clr, iss_atomic, iss_wr_class}, 0);
    @(negedge clk);
    rst = 1'b0;
    m_rd = 0; m_wr = 0; m_err = 0;
    @(posedge clk); #1;
    chk("R1", "outputs after reset", {flag_set, flag_clr, atom_reset_all, proto_err, iss_atomic, iss_wr_class}, 0);
  endtask

  task automatic step(input string req, input bit v, input int k, input bit cv, input int ck, input int ln);
    bit e_rst, e_viol, e_set, e_clr, e_at, e_wc;
    @(negedge clk);
    iss_valid = v; iss_kind = 3'(k);
    cmp_valid = cv; cmp_kind = 3'(ck); cmp_line = LW'(ln);
    e_rst = 0; e_viol = 0;
    if (v) begin
      if (k == 3) begin
        if (m_wr != 0 || m_rd == MAXG) e_viol = 1; else m_rd++;
      end else if (k == 4) begin
        if (m_rd == 0 || m_wr >= m_rd) e_viol = 1;
        else begin
          m_wr++;
          if (m_wr == m_rd) begin m_rd = 0; m_wr = 0; end
        end
      end else if (k <= 2) begin
        if (m_rd > 0 && m_wr == 0) begin e_rst = 1; m_rd = 0; m_wr = 0; end
        else if (m_wr > 0) e_viol = 1;
      end
    end
    m_err = m_err | e_viol;
    e_at  = v && (k >= 3 && k <= 6);
    e_wc  = v && (k == 1 || (k >= 3 && k <= 6));
    e_set = cv && ck == 3;
    e_clr = cv && ck == 4;
    @(posedge clk); #1;
    chk(req, "atom_reset_all", atom_reset_all, e_rst);
    chk(req, "proto_err", proto_err, m_err);
    chk(req, "iss_atomic", iss_atomic, e_at);
    chk(req, "iss_wr_class", iss_wr_class, e_wc);
    chk(req, "flag_set", flag_set, e_set);
    chk(req, "flag_clr", flag_clr, e_clr);
    if (e_set || e_clr) chk(req, "flag_line", flag_line, ln);
  endtask

  task automatic iss(input string req, input int k);
    step(req, 1'b1, k, 1'b0, 0, 0);
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 0, 1'b0, 0, 0);
  endtask

  initial begin
    do_reset();
    // R2 R3: legal paired group then a plain load
    iss("R2", 3); iss("R2", 3); iss("R3", 4); idle("R3"); iss("R3", 4);
    iss("R3", 0); iss("R3", 2); idle("R3");
    // R4: abandoned group, then a fresh legal group
    iss("R4", 3); iss("R4", 1); iss("R4", 0);
    iss("R2", 3); iss("R3", 4); iss("R4", 2);
    // R5: plain access on a half-written group
    iss("R5", 3); iss("R5", 3); iss("R5", 4); iss("R5", 1);
    idle("R6"); iss("R6", 0); idle("R6");
    do_reset();
    // R5: write with no open group
    iss("R5", 4); idle("R6");
    do_reset();
    // R5: one write too many
    iss("R5", 3); iss("R5", 4); iss("R5", 4);
    do_reset();
    // R5: read after writes started
    iss("R5", 3); iss("R5", 3); iss("R5", 4); iss("R5", 3); iss("R5", 4);
    do_reset();
    // R7: full group legal, then overflow
    for (int i = 0; i < MAXG; i++) iss("R7", 3);
    for (int i = 0; i < MAXG; i++) iss("R7", 4);
    iss("R7", 1);
    for (int i = 0; i < MAXG; i++) iss("R7", 3);
    iss("R7", 3); idle("R7");
    do_reset();
    // R8: completions
    step("R8", 0, 0, 1, 3, 26'h12345);
    step("R8", 0, 0, 1, 4, 26'h2ABCDE);
    step("R8", 0, 0, 1, 0, 26'h111);
    step("R8", 0, 0, 1, 6, 26'h222);
    idle("R8");
    // R9: every kind; locked kinds do not touch tallies
    for (int k = 0; k < 8; k++) iss("R9", k);
    iss("R9", 3); iss("R9", 5); iss("R9", 6); iss("R9", 7); iss("R9", 4); iss("R9", 0);
    // R10: abandon and flag set in one cycle; closing write with clear completion
    iss("R10", 3);
    step("R10", 1, 0, 1, 3, 26'h3FFFFFF);
    iss("R10", 3);
    step("R10", 1, 4, 1, 4, 26'h0000ABC);
    step("R10", 1, 1, 1, 3, 26'h1);
    idle("R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule